// File: doc/BRIEF.md
# Direct-Mapped Page Translation Buffer with Per-Level Permissions

This block holds a small direct-mapped table of page translations. Each entry pairs a linear page frame with a host page frame, a physical page number and an eight-bit permission map. The map has a read half and a write half, with one bit per privilege level in each half. A lookup presents a linear address, the current privilege level, the access length and a read/write select. One clock later the block reports whether the access may use the cached translation. On a hit it also returns the host address. When the hit is a permitted write, it sends a one-cycle notice that carries the physical page, so that a code cache can track writes to that page.

The slot is chosen from the linear address after adding the access length minus one. An access that runs past the end of its page therefore looks in the next page's slot and misses, and the caller splits it. Entries are written through a fill port. A single flush input clears every entry in one cycle. Page walks and fault reporting sit outside this block.

Top module: `page_perm_tlb`

## Requirements
- R1: After reset, all outputs are zero and every entry is invalid, so any lookup misses.
- R2: A fill writes the slot selected by frame bits [17:12] of the fill frame (its low 6 bits). A lookup in the same cycle as a fill sees the old contents. Later lookups see the new entry. Lookup results appear on the outputs one cycle after the lookup is presented.
- R3: A hit needs a valid slot whose stored frame equals `lookupAddr[31:12]`. A different frame that aliases to the same slot misses.
- R4: The slot index is bits [17:12] of `lookupAddr + (len-1)`, where a length of 0 counts as 1. An access whose last byte lies in the next page misses. An access ending exactly on the last byte of its page can hit.
- R5: A read is granted only when bit `pl` of the permission map (bits 3:0, one per level 0..3) is set.
- R6: A write is granted only when bit `4+pl` of the permission map (bits 7:4) is set.
- R7: On a hit, `hostAddrOut` is `{hostFrame, lookupAddr[11:0]}`. Without a hit it is zero.
- R8: A granted write hit raises `stampDecValid` for one cycle, with `stampDecPage` set to the entry's physical page. Reads and refused accesses raise nothing, and `stampDecPage` is zero whenever the pulse is low.
- R9: `flushAll` invalidates every entry in one cycle. It wins over a fill in the same cycle. A lookup in the flush cycle still sees the old contents.
- R10: A cycle without `lookupValid` yields `hitOut` and `stampDecValid` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupAddr | input | 32 | Linear address of the access |
| lookupPl | input | 2 | Current privilege level 0..3 |
| lookupLen | input | 4 | Access length in bytes (0 counts as 1) |
| lookupWrite | input | 1 | 1 = write access, 0 = read |
| fillValid | input | 1 | Write an entry this cycle |
| fillFrame | input | 20 | Linear page frame of the new entry |
| fillHostFrame | input | 20 | Host page frame of the new entry |
| fillPhysPage | input | 20 | Physical page number of the new entry |
| fillAccess | input | 8 | Permission map: [3:0] read per level, [7:4] write per level |
| flushAll | input | 1 | Invalidate all entries |
| hitOut | output | 1 | Previous-cycle lookup was granted |
| hostAddrOut | output | 32 | Translated host address, zero unless hit |
| stampDecValid | output | 1 | Write-stamp decrement pulse |
| stampDecPage | output | 20 | Physical page for the pulse, zero otherwise |

## Verification
A stale valid bit or a corrupted tag shows up on the lookup that follows. Such a lookup turns a miss into a hit, or a hit into a miss, one cycle after it is presented. Aliasing frames, page-crossing lengths and flush-then-lookup sequences are chosen so that each such fault flips `hitOut`. A wrong permission bit or a wrong half of the map flips `hitOut` and `stampDecValid` on the very next cycle. A wrong host or physical field changes `hostAddrOut` or `stampDecPage` in that same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic flushEn;    // clear every valid bit
    logic fillEn;     // write the fill slot (blocked by flush)
    logic grant;      // lookup hit with permission
    logic stampFire;  // granted write: emit decrement notice
  } tlbStrobes_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int PL_W = 2,
  localparam int LEVELS = 2 ** PL_W,
  localparam int ACC_W = 2 * LEVELS
) (
  input  logic             lookupValid,
  input  logic             lookupWrite,
  input  logic [PL_W-1:0]  lookupPl,
  input  logic             fillValid,
  input  logic             flushAll,
  input  logic             entryHit,
  input  logic [ACC_W-1:0] entryAccess,
  output tlbStrobes_t      strobes
);
  logic [LEVELS-1:0] readMap;
  logic [LEVELS-1:0] writeMap;
  logic              permBit;

  assign readMap  = entryAccess[LEVELS-1:0];
  assign writeMap = entryAccess[ACC_W-1:LEVELS];
  assign permBit  = lookupWrite ? writeMap[lookupPl] : readMap[lookupPl];

  always_comb begin
    strobes           = '0;
    strobes.flushEn   = flushAll;
    strobes.fillEn    = fillValid && !flushAll;
    strobes.grant     = lookupValid && entryHit && permBit;
    strobes.stampFire = lookupValid && entryHit && permBit && lookupWrite;
  end
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 6,
  parameter int HOST_W = 32,
  parameter int PPN_W  = 20,
  parameter int LEN_W  = 4,
  parameter int PL_W   = 2,
  localparam int ENTRIES = 2 ** IDX_W,
  localparam int FRAME_W = ADDR_W - PAGE_W,
  localparam int HFRM_W  = HOST_W - PAGE_W,
  localparam int ACC_W   = 2 * (2 ** PL_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobes_t       strobes,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [LEN_W-1:0]  lookupLen,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic [HFRM_W-1:0] fillHostFrame,
  input  logic [PPN_W-1:0]  fillPhysPage,
  input  logic [ACC_W-1:0]  fillAccess,
  output logic              entryHit,
  output logic [ACC_W-1:0]  entryAccess,
  output logic              hitOut,
  output logic [HOST_W-1:0] hostAddrOut,
  output logic              stampDecValid,
  output logic [PPN_W-1:0]  stampDecPage
);
  localparam logic [PAGE_W-1:0] PAGE_MAX = '1;

  logic [ENTRIES-1:0] validQ;
  logic [FRAME_W-1:0] tagQ  [ENTRIES];
  logic [HFRM_W-1:0]  hostQ [ENTRIES];
  logic [PPN_W-1:0]   ppnQ  [ENTRIES];
  logic [ACC_W-1:0]   accQ  [ENTRIES];

  logic [LEN_W-1:0]   lenAdj;
  logic               crossesPage;
  logic [IDX_W-1:0]   lookIdx;
  logic [IDX_W-1:0]   fillIdx;
  logic [FRAME_W-1:0] lookFrame;
  logic [PAGE_W-1:0]  lookOff;

  // Index of the slot holding the last byte touched by the access.
  assign lenAdj      = (lookupLen == '0) ? '0 : lookupLen - LEN_W'(1);
  assign lookOff     = lookupAddr[PAGE_W-1:0];
  assign lookFrame   = lookupAddr[ADDR_W-1:PAGE_W];
  assign crossesPage = lookOff > (PAGE_MAX - PAGE_W'(lenAdj));
  assign lookIdx     = lookFrame[IDX_W-1:0] + IDX_W'(crossesPage);
  assign fillIdx     = fillFrame[IDX_W-1:0];

  assign entryHit    = validQ[lookIdx] && (tagQ[lookIdx] == lookFrame);
  assign entryAccess = accQ[lookIdx];

  // Valid bits: flush beats fill.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobes.flushEn) begin
      validQ <= '0;
    end else if (strobes.fillEn) begin
      validQ[fillIdx] <= 1'b1;
    end
  end

  // Entry payload, no reset needed behind the valid bit.
  always_ff @(posedge clk) begin
    if (strobes.fillEn) begin
      tagQ[fillIdx]  <= fillFrame;
      hostQ[fillIdx] <= fillHostFrame;
      ppnQ[fillIdx]  <= fillPhysPage;
      accQ[fillIdx]  <= fillAccess;
    end
  end

  // Registered results, one cycle after the lookup.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitOut        <= 1'b0;
      hostAddrOut   <= '0;
      stampDecValid <= 1'b0;
      stampDecPage  <= '0;
    end else begin
      hitOut        <= strobes.grant;
      hostAddrOut   <= strobes.grant ? {hostQ[lookIdx], lookOff} : '0;
      stampDecValid <= strobes.stampFire;
      stampDecPage  <= strobes.stampFire ? ppnQ[lookIdx] : '0;
    end
  end

  assert_pulse_needs_hit_R8 : assert property (@(posedge clk) disable iff (!rstN)
    stampDecValid |-> hitOut);
  assert_offset_kept_R7 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.grant |=> hostAddrOut[PAGE_W-1:0] == $past(lookOff));
  assert_miss_zero_addr_R7 : assert property (@(posedge clk) disable iff (!rstN)
    !hitOut |-> hostAddrOut == '0);
  assert_page_zero_idle_R8 : assert property (@(posedge clk) disable iff (!rstN)
    !stampDecValid |-> stampDecPage == '0);
endmodule

// File: rtl/page_perm_tlb.sv
module page_perm_tlb
  import tlb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 6,
  parameter int HOST_W = 32,
  parameter int PPN_W  = 20,
  parameter int LEN_W  = 4,
  parameter int PL_W   = 2,
  localparam int FRAME_W = ADDR_W - PAGE_W,
  localparam int HFRM_W  = HOST_W - PAGE_W,
  localparam int ACC_W   = 2 * (2 ** PL_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic [PL_W-1:0]    lookupPl,
  input  logic [LEN_W-1:0]   lookupLen,
  input  logic               lookupWrite,
  input  logic               fillValid,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic [HFRM_W-1:0]  fillHostFrame,
  input  logic [PPN_W-1:0]   fillPhysPage,
  input  logic [ACC_W-1:0]   fillAccess,
  input  logic               flushAll,
  output logic               hitOut,
  output logic [HOST_W-1:0]  hostAddrOut,
  output logic               stampDecValid,
  output logic [PPN_W-1:0]   stampDecPage
);
  tlbStrobes_t      strobes;
  logic             entryHit;
  logic [ACC_W-1:0] entryAccess;

  tlb_ctrl #(.PL_W(PL_W)) i_ctrl (
    .lookupValid (lookupValid),
    .lookupWrite (lookupWrite),
    .lookupPl    (lookupPl),
    .fillValid   (fillValid),
    .flushAll    (flushAll),
    .entryHit    (entryHit),
    .entryAccess (entryAccess),
    .strobes     (strobes)
  );

  tlb_datapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .HOST_W(HOST_W),
    .PPN_W(PPN_W), .LEN_W(LEN_W), .PL_W(PL_W)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .lookupAddr    (lookupAddr),
    .lookupLen     (lookupLen),
    .fillFrame     (fillFrame),
    .fillHostFrame (fillHostFrame),
    .fillPhysPage  (fillPhysPage),
    .fillAccess    (fillAccess),
    .entryHit      (entryHit),
    .entryAccess   (entryAccess),
    .hitOut        (hitOut),
    .hostAddrOut   (hostAddrOut),
    .stampDecValid (stampDecValid),
    .stampDecPage  (stampDecPage)
  );

  assert_idle_quiet_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> (!hitOut && !stampDecValid));
  assert_stamp_is_write_R8 : assert property (@(posedge clk) disable iff (!rstN)
    stampDecValid |-> $past(lookupWrite));
  assert_flush_empties_R9 : assert property (@(posedge clk) disable iff (!rstN)
    ($past(flushAll) && lookupValid) |=> !hitOut);
endmodule

// File: tb/test_page_perm_tlb.sv
module test_page_perm_tlb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic [1:0]  lookupPl = '0;
  logic [3:0]  lookupLen = '0;
  logic        lookupWrite = 1'b0;
  logic        fillValid = 1'b0;
  logic [19:0] fillFrame = '0;
  logic [19:0] fillHostFrame = '0;
  logic [19:0] fillPhysPage = '0;
  logic [7:0]  fillAccess = '0;
  logic        flushAll = 1'b0;
  logic        hitOut;
  logic [31:0] hostAddrOut;
  logic        stampDecValid;
  logic [19:0] stampDecPage;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_perm_tlb i_page_perm_tlb (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .lookupPl(lookupPl), .lookupLen(lookupLen), .lookupWrite(lookupWrite),
    .fillValid(fillValid), .fillFrame(fillFrame), .fillHostFrame(fillHostFrame),
    .fillPhysPage(fillPhysPage), .fillAccess(fillAccess), .flushAll(flushAll),
    .hitOut(hitOut), .hostAddrOut(hostAddrOut), .stampDecValid(stampDecValid),
    .stampDecPage(stampDecPage)
  );

  typedef struct packed {
    logic        isFill;
    logic [31:0] addr;
    logic [1:0]  pl;
    logic [3:0]  len;
    logic        wr;
    logic [19:0] host;
    logic [19:0] ppn;
    logic [7:0]  acc;
    logic        expHit;
    logic [31:0] expAddr;
    logic        expStamp;
    logic [19:0] expPage;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // fills: frame 0x12 read all / write pl0; frame 0x35 pl3 only; frame 0x36 all
    '{1'b1, 32'h0001_2000, 2'd0, 4'd0, 1'b0, 20'hABCDE, 20'h00111, 8'h1F, 1'b0, 32'h0, 1'b0, 20'h0, 8'd2},
    '{1'b1, 32'h0003_5000, 2'd0, 4'd0, 1'b0, 20'h12345, 20'h00222, 8'h88, 1'b0, 32'h0, 1'b0, 20'h0, 8'd2},
    '{1'b1, 32'h0003_6000, 2'd0, 4'd0, 1'b0, 20'h55555, 20'h00333, 8'hFF, 1'b0, 32'h0, 1'b0, 20'h0, 8'd2},
    // R5 R7: read at pl3 granted, address composed
    '{1'b0, 32'h0001_2ABC, 2'd3, 4'd4, 1'b0, 20'h0, 20'h0, 8'h0, 1'b1, 32'hABCD_EABC, 1'b0, 20'h0, 8'd5},
    // R6 R8: write at pl0 granted, pulse carries physical page
    '{1'b0, 32'h0001_2010, 2'd0, 4'd4, 1'b1, 20'h0, 20'h0, 8'h0, 1'b1, 32'hABCD_E010, 1'b1, 20'h00111, 8'd6},
    // R6: write at pl1 refused
    '{1'b0, 32'h0001_2010, 2'd1, 4'd4, 1'b1, 20'h0, 20'h0, 8'h0, 1'b0, 32'h0, 1'b0, 20'h0, 8'd6},
    // R5: read at pl2 refused
    '{1'b0, 32'h0003_5000, 2'd2, 4'd1, 1'b0, 20'h0, 20'h0, 8'h0, 1'b0, 32'h0, 1'b0, 20'h0, 8'd5},
    // R4: single byte on last byte of page hits
    '{1'b0, 32'h0003_5FFF, 2'd3, 4'd1, 1'b0, 20'h0, 20'h0, 8'h0, 1'b1, 32'h1234_5FFF, 1'b0, 20'h0, 8'd4},
    // R4: four bytes crossing into next page miss
    '{1'b0, 32'h0003_5FFE, 2'd3, 4'd4, 1'b0, 20'h0, 20'h0, 8'h0, 1'b0, 32'h0, 1'b0, 20'h0, 8'd4},
    // R4: four bytes ending on last byte hit
    '{1'b0, 32'h0003_5FFC, 2'd3, 4'd4, 1'b0, 20'h0, 20'h0, 8'h0, 1'b1, 32'h1234_5FFC, 1'b0, 20'h0, 8'd4},
    // R4: length 0 counts as 1
    '{1'b0, 32'h0003_5FFF, 2'd3, 4'd0, 1'b0, 20'h0, 20'h0, 8'h0, 1'b1, 32'h1234_5FFF, 1'b0, 20'h0, 8'd4},
    // R3: frame 0x52 aliases slot 0x12, misses
    '{1'b0, 32'h0005_2000, 2'd0, 4'd1, 1'b0, 20'h0, 20'h0, 8'h0, 1'b0, 32'h0, 1'b0, 20'h0, 8'd3},
    // R8: write pl2 on frame 0x36
    '{1'b0, 32'h0003_6123, 2'd2, 4'd2, 1'b1, 20'h0, 20'h0, 8'h0, 1'b1, 32'h5555_5123, 1'b1, 20'h00333, 8'd8},
    // R8: write pl3 on frame 0x35
    '{1'b0, 32'h0003_5800, 2'd3, 4'd4, 1'b1, 20'h0, 20'h0, 8'h0, 1'b1, 32'h1234_5800, 1'b1, 20'h00222, 8'd8}
  };

  task automatic checkOut(input string tag, input logic eHit, input logic [31:0] eAddr,
                          input logic eStamp, input logic [19:0] ePage);
    checks++;
    if (hitOut !== eHit || hostAddrOut !== eAddr || stampDecValid !== eStamp ||
        stampDecPage !== ePage) begin
      failures++;
      $display("FAIL %s: actual hit=%b addr=%h stamp=%b page=%h expected hit=%b addr=%h stamp=%b page=%h",
               tag, hitOut, hostAddrOut, stampDecValid, stampDecPage, eHit, eAddr, eStamp, ePage);
    end
  endtask

  task automatic setFill(input logic [19:0] frame, input logic [19:0] host,
                         input logic [19:0] ppn, input logic [7:0] acc);
    fillValid = 1'b1; fillFrame = frame; fillHostFrame = host;
    fillPhysPage = ppn; fillAccess = acc;
  endtask

  task automatic setLookup(input logic [31:0] addr, input logic [1:0] pl,
                           input logic [3:0] len, input logic wr);
    lookupValid = 1'b1; lookupAddr = addr; lookupPl = pl; lookupLen = len; lookupWrite = wr;
  endtask

  task automatic clearAll();
    lookupValid = 1'b0; fillValid = 1'b0; flushAll = 1'b0;
  endtask

  task automatic stepCheck(input string tag, input logic eHit, input logic [31:0] eAddr,
                           input logic eStamp, input logic [19:0] ePage);
    @(negedge clk);
    clearAll();
    checkOut(tag, eHit, eAddr, eStamp, ePage);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values and empty table
    checkOut("R1 reset outputs", 1'b0, 32'h0, 1'b0, 20'h0);
    setLookup(32'h0001_2000, 2'd0, 4'd1, 1'b0);
    stepCheck("R1 empty table miss", 1'b0, 32'h0, 1'b0, 20'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isFill) begin
        setFill(VECS[i].addr[31:12], VECS[i].host, VECS[i].ppn, VECS[i].acc);
        @(negedge clk);
        clearAll();
      end else begin
        setLookup(VECS[i].addr, VECS[i].pl, VECS[i].len, VECS[i].wr);
        stepCheck($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].expHit,
                  VECS[i].expAddr, VECS[i].expStamp, VECS[i].expPage);
      end
    end

    // R10: outputs drop after an idle cycle following a granted write
    setLookup(32'h0001_2010, 2'd0, 4'd4, 1'b1);
    stepCheck("R10 write hit", 1'b1, 32'hABCD_E010, 1'b1, 20'h00111);
    @(negedge clk);
    checkOut("R10 idle after hit", 1'b0, 32'h0, 1'b0, 20'h0);

    // R9: lookup in flush cycle sees old contents, then table is empty
    flushAll = 1'b1;
    setLookup(32'h0001_2ABC, 2'd0, 4'd1, 1'b0);
    stepCheck("R9 lookup during flush", 1'b1, 32'hABCD_EABC, 1'b0, 20'h0);
    setLookup(32'h0003_6000, 2'd0, 4'd1, 1'b0);
    stepCheck("R9 miss after flush", 1'b0, 32'h0, 1'b0, 20'h0);

    // R9: flush wins over same-cycle fill
    flushAll = 1'b1;
    setFill(20'h00012, 20'hABCDE, 20'h00111, 8'hFF);
    @(negedge clk);
    clearAll();
    setLookup(32'h0001_2000, 2'd0, 4'd1, 1'b0);
    stepCheck("R9 flush beats fill", 1'b0, 32'h0, 1'b0, 20'h0);

    // R2: lookup in the fill cycle sees old contents, next lookup sees the fill
    setFill(20'h00012, 20'h0BEEF, 20'h00444, 8'h01);
    setLookup(32'h0001_2345, 2'd0, 4'd1, 1'b0);
    stepCheck("R2 same-cycle fill", 1'b0, 32'h0, 1'b0, 20'h0);
    setLookup(32'h0001_2345, 2'd0, 4'd1, 1'b0);
    stepCheck("R2 after fill", 1'b1, 32'h0BEE_F345, 1'b0, 20'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule